// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives asynchronous serial characters on one line and hands each finished character to a separate register block, together with a set of status events. A baud divider produces a sample tick at sixteen times the bit rate. A state machine finds the start of each character, takes a three-sample majority vote at the centre of every bit, collects 8 or 9 data bits least significant bit first, and checks the parity and the stop bit. A watcher on the line reports an idle line, either counted from the first one seen or counted only after a character has ended.

A sleep mode lets a receiver on a shared line skip characters meant for other nodes. It wakes either on an idle line or on a character whose last data bit is one. A loopback input can take the place of the pin. The state machine has four states. HUNT waits for a falling edge. START confirms the start bit by vote, or returns to HUNT when the vote is one (start rejected). DATA collects the data bits and moves to STOP after the last one. STOP votes the stop bit, finishes the character and returns to HUNT. Dropping `rx_enable` forces HUNT from any state.

Top module: `osr_uart_rx`

## Requirements
- R1: With a divisor `baud_div` = D (1 to 8191), one bit lasts 32·D clock cycles. A sample tick comes every 2·D cycles. With D = 0 no tick is produced and nothing is received.
- R2: A character is one low start bit, then 8 data bits (`wide_frame`=0) or 9 data bits (`wide_frame`=1) least significant first, then one stop bit. The data bits appear in `rx_data` bit 0 upward, and `rx_data[8]` is 0 for 8-bit characters.
- R3: With `parity_on`=1, the top data bit is the parity bit. `parity_err` is set when the XOR of all data bits differs from `parity_odd`, where 0 selects even parity and 1 selects odd parity. With `parity_on`=0, `parity_err` stays 0.
- R4: Each bit is decided by majority of the sample ticks numbered 7, 8 and 9 after the start edge. A disagreement among the three samples of a received character sets `noise_err`. A start whose vote is one is rejected, and no character results.
- R5: A stop-bit vote of zero sets `frame_err`. A break (all zeros including the stop bit) still delivers a character of value 0 with `frame_err` set.
- R6: `noise_err`, `frame_err` and `parity_err` rise only in the same cycle that `rx_full` rises.
- R7: When a character ends while `rx_full` is 1, `overrun` is set, `rx_data` keeps the older character, and the new character is lost.
- R8: `line_idle` sets after 16·(frame bits) ticks of continuous ones. With `idle_after_stop`=0 the count starts from any one. With `idle_after_stop`=1 it starts only after the stop bit. After reset, or once set, `line_idle` cannot set again until a character has been delivered.
- R9: `rx_busy` sets on a falling edge that may be a start bit. It clears when the idle condition is reached.
- R10: A `sleep_req` pulse sets `sleeping`. While it is set, characters are not delivered and no flag rises. It clears on an idle line (`wake_on_mark`=0), with no `line_idle` flag. It also clears on a character whose last data bit is 1 (`wake_on_mark`=1), and that character is delivered.
- R11: With `loop_en`=1 the receiver reads `loop_in` and ignores `rx_pin`.
- R12: A `data_taken` pulse clears `rx_full`, `overrun`, `noise_err`, `frame_err` and `parity_err`. An `idle_taken` pulse clears `line_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver on; 0 holds HUNT |
| baud_div | input | 13 | Baud divisor, 0 stops the tick |
| wide_frame | input | 1 | 1 selects 9 data bits |
| parity_on | input | 1 | Top data bit is parity |
| parity_odd | input | 1 | Parity sense, 1 = odd |
| idle_after_stop | input | 1 | Idle count starts only after the stop bit |
| wake_on_mark | input | 1 | Wake source: 1 = marked character, 0 = idle line |
| sleep_req | input | 1 | Pulse that enters sleep mode |
| loop_en | input | 1 | Take the line from loop_in |
| loop_in | input | 1 | Looped-back transmit line |
| rx_pin | input | 1 | Serial input pin |
| data_taken | input | 1 | Pulse: data register read |
| idle_taken | input | 1 | Pulse: idle flag acknowledged |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | New character present |
| rx_busy | output | 1 | Receiver active |
| line_idle | output | 1 | Idle line detected |
| overrun | output | 1 | Character lost to a full register |
| noise_err | output | 1 | Sample disagreement in the character |
| frame_err | output | 1 | Stop bit read as zero |
| parity_err | output | 1 | Parity mismatch |
| sleeping | output | 1 | Sleep mode active |

## Verification
On every cycle the assertions check the following. Error flags rise only together with a new character. The data register does not change while a character is pending. `overrun` never stands without `rx_full`. No flag rises while the receiver stays asleep. `rx_busy` is low whenever the idle flag rises. The scenarios alone show the bit-level behaviour: the majority vote and the noise flag, the parity sense for both widths, the break, the short and long idle timing, the two wake sources, loopback, and the bit period at two divisors.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/osr_rx_baud.sv
module osr_rx_baud #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             run;

    assign last = {divisor, 1'b0} - CNT_W'(1);
    assign run  = (divisor != '0);
    assign tick = run && (cnt >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || tick)   cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/osr_rx_sync.sv
module osr_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic loop_in,
    input  logic pin,
    output logic line
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], (loop_en ? loop_in : pin)};
    end

    assign line = q[STAGES-1];
endmodule

// File: rtl/osr_rx_idle.sv
module osr_rx_idle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             line,
    input  logic             count_en,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] run_len;

    assign hit = tick && line && count_en && (run_len == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_len <= '0;
        else if (clr)               run_len <= '0;
        else if (tick) begin
            if (!line)              run_len <= '0;
            else if (count_en && run_len < limit)
                                    run_len <= run_len + CNT_W'(1);
        end
    end
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
    import osr_rx_pkg::*;
#(
    parameter int DIV_W    = 13,
    parameter int OSR      = 16,
    parameter int MAX_BITS = 9,
    parameter int SYNC     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_enable,
    input  logic [DIV_W-1:0]    baud_div,
    input  logic                wide_frame,
    input  logic                parity_on,
    input  logic                parity_odd,
    input  logic                idle_after_stop,
    input  logic                wake_on_mark,
    input  logic                sleep_req,
    input  logic                loop_en,
    input  logic                loop_in,
    input  logic                rx_pin,
    input  logic                data_taken,
    input  logic                idle_taken,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_full,
    output logic                rx_busy,
    output logic                line_idle,
    output logic                overrun,
    output logic                noise_err,
    output logic                frame_err,
    output logic                parity_err,
    output logic                sleeping
);
    localparam int SUB_W  = $clog2(OSR);
    localparam int IDX_W  = $clog2(MAX_BITS + 1);
    localparam int IDLE_W = $clog2(OSR * (MAX_BITS + 2) + 1);
    localparam logic [SUB_W-1:0] S_A    = SUB_W'(OSR / 2 - 1);
    localparam logic [SUB_W-1:0] S_B    = SUB_W'(OSR / 2);
    localparam logic [SUB_W-1:0] S_C    = SUB_W'(OSR / 2 + 1);
    localparam logic [SUB_W-1:0] S_LAST = SUB_W'(OSR - 1);
    localparam logic [IDLE_W-1:0] IDLE_WIDE   = IDLE_W'(OSR * (MAX_BITS + 2));
    localparam logic [IDLE_W-1:0] IDLE_NARROW = IDLE_W'(OSR * (MAX_BITS + 1));

    rx_state_t         state, state_nx;
    logic [SUB_W-1:0]  sub;
    logic [IDX_W-1:0]  idx, idx_last;
    logic [MAX_BITS-1:0] sh;
    logic              tick, line, prev_line, smp_a, smp_b, noise_acc;
    logic              vote, split, fall, mid, bit_end, frame_done;
    logic              idle_hit, mark_bit, deliver, full_busy, pf_now;
    logic              idle_armed;

    osr_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(baud_div), .tick(tick)
    );

    osr_rx_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .loop_in(loop_in),
        .pin(rx_pin), .line(line)
    );

    osr_rx_idle #(.CNT_W(IDLE_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .clr(!rx_enable), .tick(tick), .line(line),
        .count_en(!idle_after_stop || state == ST_HUNT),
        .limit(wide_frame ? IDLE_WIDE : IDLE_NARROW), .hit(idle_hit)
    );

    assign idx_last   = wide_frame ? IDX_W'(MAX_BITS - 1) : IDX_W'(MAX_BITS - 2);
    assign vote       = maj3(smp_a, smp_b, line);
    assign split      = !((smp_a == smp_b) && (smp_b == line));
    assign fall       = tick && (state == ST_HUNT) && prev_line && !line;
    assign mid        = tick && (sub == S_C);
    assign bit_end    = tick && (sub == S_LAST);
    assign frame_done = (state == ST_STOP) && mid;
    assign mark_bit   = sh[idx_last];
    assign deliver    = !sleeping || (wake_on_mark && mark_bit);
    assign full_busy  = rx_full && !data_taken;
    assign pf_now     = parity_on && ((^sh) != parity_odd);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (fall) state_nx = ST_START;
            ST_START: if (mid && vote) state_nx = ST_HUNT;
                      else if (bit_end) state_nx = ST_DATA;
            ST_DATA:  if (bit_end && idx == idx_last) state_nx = ST_STOP;
            ST_STOP:  if (mid) state_nx = ST_HUNT;
        endcase
        if (!rx_enable) state_nx = ST_HUNT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub <= '0; idx <= '0; sh <= '0; prev_line <= 1'b0;
            smp_a <= 1'b1; smp_b <= 1'b1; noise_acc <= 1'b0;
            rx_data <= '0; rx_full <= 1'b0; rx_busy <= 1'b0;
            line_idle <= 1'b0; overrun <= 1'b0; noise_err <= 1'b0;
            frame_err <= 1'b0; parity_err <= 1'b0; sleeping <= 1'b0;
            idle_armed <= 1'b0;
        end else begin
            if (sleep_req) sleeping <= 1'b1;
            if (idle_taken) line_idle <= 1'b0;
            if (data_taken) begin
                rx_full <= 1'b0; overrun <= 1'b0; noise_err <= 1'b0;
                frame_err <= 1'b0; parity_err <= 1'b0;
            end
            if (!rx_enable) begin
                sub <= '0; idx <= '0; prev_line <= 1'b0;
            end else begin
                if (tick) begin
                    prev_line <= line;
                    sub <= (state == ST_HUNT) ? (fall ? SUB_W'(1) : '0) : sub + SUB_W'(1);
                    if (sub == S_A) smp_a <= line;
                    if (sub == S_B) smp_b <= line;
                end
                if (fall) begin
                    idx <= '0; sh <= '0; noise_acc <= 1'b0; rx_busy <= 1'b1;
                end
                if (mid && state == ST_START) noise_acc <= split;
                if (mid && state == ST_DATA) begin
                    sh[idx]   <= vote;
                    noise_acc <= noise_acc | split;
                end
                if (bit_end && state == ST_DATA && idx != idx_last)
                    idx <= idx + IDX_W'(1);
                if (frame_done && deliver) begin
                    sleeping <= 1'b0;
                    if (full_busy) overrun <= 1'b1;
                    else begin
                        rx_data    <= sh;
                        rx_full    <= 1'b1;
                        noise_err  <= noise_acc | split;
                        frame_err  <= !vote;
                        parity_err <= pf_now;
                        idle_armed <= 1'b1;
                    end
                end
                if (idle_hit) begin
                    rx_busy <= 1'b0;
                    if (sleeping && !wake_on_mark) sleeping <= 1'b0;
                    else if (!sleeping && idle_armed) begin
                        line_idle  <= 1'b1;
                        idle_armed <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk #(
    parameter int MAX_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_full,
    input logic                rx_busy,
    input logic                line_idle,
    input logic                overrun,
    input logic                noise_err,
    input logic                frame_err,
    input logic                parity_err,
    input logic                sleeping
);
    AST_ERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(noise_err) || $rose(frame_err) || $rose(parity_err)) |-> $rose(rx_full)); // R6

    AST_HELD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && $past(rx_full)) |-> $stable(rx_data)); // R7

    AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> rx_full); // R7

    AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && $past(sleeping)) |-> !($rose(rx_full) || $rose(line_idle))); // R10

    AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_idle) |-> !rx_busy); // R9
endmodule

bind osr_uart_rx osr_uart_rx_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_full(rx_full),
    .rx_busy(rx_busy), .line_idle(line_idle), .overrun(overrun),
    .noise_err(noise_err), .frame_err(frame_err), .parity_err(parity_err),
    .sleeping(sleeping)
);

// File: tb/osr_uart_rx_test.sv
module osr_uart_rx_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_enable = 1'b1;
    logic [12:0] baud_div = 13'd1;
    logic wide_frame = 0, parity_on = 0, parity_odd = 0, idle_after_stop = 0;
    logic wake_on_mark = 0, sleep_req = 0, loop_en = 0, loop_in = 1, rx_pin = 1;
    logic data_taken = 0, idle_taken = 0;
    logic [8:0] rx_data;
    logic rx_full, rx_busy, line_idle, overrun, noise_err, frame_err, parity_err, sleeping;
    int checks = 0, fails = 0;
    int bc = 32;

    osr_uart_rx uut (.*);

    always #10 clk = ~clk;

    // vector: [12] wide, [11] parity on, [10] odd, [9] stop value, [8:0] data field
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 9'h05A},
        {1'b0, 1'b1, 1'b0, 1'b1, 9'h003},
        {1'b0, 1'b1, 1'b0, 1'b1, 9'h007},
        {1'b0, 1'b1, 1'b1, 1'b1, 9'h007},
        {1'b1, 1'b0, 1'b0, 1'b1, 9'h1A5},
        {1'b1, 1'b1, 1'b1, 1'b1, 9'h100},
        {1'b1, 1'b1, 1'b0, 1'b1, 9'h100},
        {1'b0, 1'b0, 1'b0, 1'b0, 9'h0C3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic v, input logic via_loop);
        if (via_loop) loop_in = v; else rx_pin = v;
    endtask

    // gbit >= 0 flips the middle sample of that data bit
    task automatic send(input logic [8:0] field, input int nb, input logic stop_v,
                        input int gbit, input logic via_loop);
        put(1'b0, via_loop); wait_clk(bc);
        for (int b = 0; b < nb; b++) begin
            put(field[b], via_loop);
            if (b == gbit) begin
                wait_clk(16); put(!field[b], via_loop);
                wait_clk(2);  put(field[b], via_loop);
                wait_clk(bc - 18);
            end else wait_clk(bc);
        end
        put(stop_v, via_loop); wait_clk(bc);
        put(1'b1, via_loop); wait_clk(2 * bc);
    endtask

    task automatic take_data;
        data_taken = 1'b1; wait_clk(1); data_taken = 1'b0;
    endtask

    task automatic take_idle;
        idle_taken = 1'b1; wait_clk(1); idle_taken = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        wait_clk(3);
        chk("reset rx_full R12", rx_full, 0);
        chk("reset flags R8", {line_idle, rx_busy, overrun, sleeping}, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // table walk: R2 R3 R5 R6
        for (int i = 0; i < 8; i++) begin
            logic [8:0] f;
            int nb;
            logic pexp;
            wide_frame = VEC[i][12]; parity_on = VEC[i][11]; parity_odd = VEC[i][10];
            nb = VEC[i][12] ? 9 : 8;
            f = VEC[i][8:0];
            pexp = VEC[i][11] && ((^f) != VEC[i][10]);
            send(f, nb, VEC[i][9], -1, 1'b0);
            chk("R2 data", rx_data, f);
            chk("R2 full", rx_full, 1);
            chk("R3 parity", parity_err, pexp);
            chk("R5 stop", frame_err, !VEC[i][9]);
            chk("R6 noise clean", noise_err, 0);
            take_data();
            chk("R12 clear", {rx_full, parity_err, frame_err}, 0);
        end
        wide_frame = 0; parity_on = 0; parity_odd = 0;

        // R7 overrun
        send(9'h011, 8, 1'b1, -1, 1'b0);
        chk("R9 busy after char", rx_busy, 1);
        send(9'h022, 8, 1'b1, -1, 1'b0);
        chk("R7 overrun set", overrun, 1);
        chk("R7 old data kept", rx_data, 9'h011);
        take_data();
        chk("R12 overrun clear", {overrun, rx_full}, 0);

        // R8 R9 idle after a delivered char
        wait_clk(12 * bc);
        chk("R8 idle set", line_idle, 1);
        chk("R9 busy clear", rx_busy, 0);
        take_idle();
        chk("R12 idle clear", line_idle, 0);
        wait_clk(12 * bc);
        chk("R8 idle not rearmed", line_idle, 0);

        // R8 short vs long count on 0xFF
        send(9'h0FF, 8, 1'b1, -1, 1'b0);
        take_data();
        wait_clk(bc);
        chk("R8 short idle early", line_idle, 1);
        take_idle();
        idle_after_stop = 1'b1;
        send(9'h0FF, 8, 1'b1, -1, 1'b0);
        take_data();
        wait_clk(bc);
        chk("R8 long idle not yet", line_idle, 0);
        wait_clk(10 * bc);
        chk("R8 long idle later", line_idle, 1);
        take_idle();
        idle_after_stop = 1'b0;

        // R4 noise by majority
        send(9'h000, 8, 1'b1, 2, 1'b0);
        chk("R4 vote data", rx_data, 9'h000);
        chk("R4 noise flag", noise_err, 1);
        take_data();

        // R4 rejected start
        rx_pin = 1'b0; wait_clk(2); rx_pin = 1'b1;
        wait_clk(12 * bc);
        chk("R4 reject no char", rx_full, 0);
        take_idle();

        // R5 break
        send(9'h000, 8, 1'b0, -1, 1'b0);
        chk("R5 break full", rx_full, 1);
        chk("R5 break frame err", {frame_err, rx_data}, {1'b1, 9'h000});
        take_data();
        wait_clk(12 * bc);
        take_idle();

        // R10 wake on mark
        wake_on_mark = 1'b1;
        sleep_req = 1'b1; wait_clk(1); sleep_req = 1'b0;
        send(9'h005, 8, 1'b1, -1, 1'b0);
        chk("R10 unmarked ignored", {sleeping, rx_full}, 2'b10);
        send(9'h085, 8, 1'b1, -1, 1'b0);
        chk("R10 mark wakes", {sleeping, rx_full}, 2'b01);
        chk("R10 mark delivered", rx_data, 9'h085);
        take_data();

        // R10 wake on idle, idle flag suppressed
        wake_on_mark = 1'b0;
        sleep_req = 1'b1; wait_clk(1); sleep_req = 1'b0;
        send(9'h012, 8, 1'b1, -1, 1'b0);
        chk("R10 asleep ignored", {sleeping, rx_full}, 2'b10);
        wait_clk(12 * bc);
        chk("R10 idle wakes", {sleeping, line_idle}, 2'b00);

        // R11 loopback
        loop_en = 1'b1; wait_clk(4);
        send(9'h03C, 8, 1'b1, -1, 1'b1);
        chk("R11 loop data", {rx_full, rx_data}, {1'b1, 9'h03C});
        take_data();
        loop_en = 1'b0; wait_clk(4);

        // R1 divisor 2 and divisor 0
        baud_div = 13'd2; bc = 64; wait_clk(4);
        send(9'h0A6, 8, 1'b1, -1, 1'b0);
        chk("R1 div2 data", {rx_full, rx_data}, {1'b1, 9'h0A6});
        take_data();
        baud_div = 13'd0; bc = 32; wait_clk(4);
        send(9'h055, 8, 1'b1, -1, 1'b0);
        wait_clk(4 * bc);
        chk("R1 div0 nothing", rx_full, 0);

        summary();
        $finish;
    end
endmodule